// File: doc/BRIEF.md
# Operand Bypass and Load-Stall Control for an In-Order Pipeline

This block decides, every cycle, where the two ALU operands of the instruction in the execute stage come from, and whether the front of a five-stage in-order pipeline must pause. A result that a later instruction needs may still sit in the EX/MEM or MEM/WB pipeline buffer and not yet be in the register file. For each execute-stage source register, the block compares the register number against the destination numbers held in those two buffers. It then drives a bypass select for each operand.

Most read-after-write dependences are covered by bypassing. The one exception is a load whose destination is read by the instruction right behind it. In that case the block raises a stall for one cycle. The stall freezes the program counter and the IF/ID register, and it clears the ID/EX control fields so that a no-op bubble enters execute. After the bubble, the loaded value reaches the consumer through the MEM/WB bypass.

The register file writes in the first half of a cycle and reads in the second half. A producer that has reached WB is therefore already visible to decode, and the block has no WB-to-decode path. Issue and writeback are in order, so write-after-write and write-after-read cases need no logic.

A two-state machine paces the stall. In state `ST_FLOW` the block runs normally. On the transition FLOW→HOLD, taken in the cycle a stall is raised, the machine moves to `ST_HOLD`. In `ST_HOLD` no stall is raised. On the transition HOLD→FLOW, which is unconditional, it returns to `ST_FLOW` on the next cycle. Reset puts the machine in `ST_FLOW`.

Top module: `hz_fwd_unit`

## Requirements
- R1: When `mem_wen` is high, `mem_rd` is nonzero and `mem_rd` equals an execute source, that operand's select is 2'b10 (bypass from EX/MEM).
- R2: When `wb_wen` is high, `wb_rd` is nonzero, `wb_rd` equals an execute source and R1 does not apply to that operand, its select is 2'b01 (bypass from MEM/WB). With no match, the select is 2'b00 (register file).
- R3: When both buffers match the same execute source, the EX/MEM bypass (2'b10) wins.
- R4: A destination equal to register zero, or a producer whose write enable is low, causes neither a bypass nor a stall.
- R5: `stall` and `bubble` go high in the same cycle when `ex_mrd`, `ex_wen` and a nonzero `ex_rd` equal to `id_rs1` or `id_rs2` are all present, with the machine in `ST_FLOW`.
- R6: A stall lasts exactly one cycle. In the cycle after a stall (`ST_HOLD`), `stall` is low even if the inputs still show a load-use match. In the cycle after that, a match stalls again.
- R7: An ALU producer in execute (`ex_mrd` low) never stalls. A producer in WB whose result is read by decode causes no bypass and no stall.
- R8: While `rst_n` is low, `stall` and `bubble` are low. The first cycle after reset is in `ST_FLOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_rs1 | input | REG_AW | First source register of the execute instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination held in ID/EX |
| ex_wen | input | 1 | Register write enable held in ID/EX |
| ex_mrd | input | 1 | Memory-read (load) flag held in ID/EX |
| mem_rd | input | REG_AW | Destination held in EX/MEM |
| mem_wen | input | 1 | Register write enable held in EX/MEM |
| wb_rd | input | REG_AW | Destination held in MEM/WB |
| wb_wen | input | 1 | Register write enable held in MEM/WB |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 MEM/WB, 10 EX/MEM |
| fwd_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold PC and IF/ID |
| bubble | output | 1 | Clear ID/EX control fields |

## Verification
The bench builds the block with the default `REG_AW` of 5. This gives 32 register numbers, so register zero and many distinct nonzero indices can appear side by side in one vector. The vectors cover dependences at distances one, two and three, from both ALU and load producers. They include a case where both buffers match the same operand, and they hold a load-use pattern over three cycles to walk the FLOW→HOLD→FLOW sequence.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int NUM_SRC = 2;

    typedef enum logic [1:0] {
        FWD_NONE = 2'b00,
        FWD_WB   = 2'b01,
        FWD_MEM  = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } hz_state_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output fwd_sel_e          sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit)      sel = FWD_MEM;   // nearer producer has the newer value
        else if (wb_hit)  sel = FWD_WB;
        else              sel = FWD_NONE;
    end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_wen,
    input  logic                           ex_mrd,
    output logic                           hit
);
    logic [NUM_SRC-1:0] src_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = (id_src[g] == ex_rd);
    end

    assign hit = ex_mrd && ex_wen && (ex_rd != '0) && (|src_hit);
endmodule

// File: rtl/hz_stall_fsm.sv
module hz_stall_fsm
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_hit,
    output logic stall,
    output logic bubble
);
    hz_state_e state_q;
    hz_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        stall   = 1'b0;
        bubble  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: begin
                if (rst_n && load_hit) begin
                    stall   = 1'b1;
                    bubble  = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_FLOW;
            end
            default: state_d = ST_FLOW;
        endcase
    end

    // R6
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_mrd,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              stall,
    output logic              bubble
);
    logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
    logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
    fwd_sel_e [NUM_SRC-1:0]         sel;
    logic                           load_hit;

    assign ex_src = {ex_rs2, ex_rs1};
    assign id_src = {id_rs2, id_rs1};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        hz_fwd_sel #(.REG_AW(REG_AW)) u_sel (
            .src    (ex_src[g]),
            .mem_rd (mem_rd),
            .mem_wen(mem_wen),
            .wb_rd  (wb_rd),
            .wb_wen (wb_wen),
            .sel    (sel[g])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    hz_loaduse_det #(.REG_AW(REG_AW)) u_det (
        .id_src(id_src),
        .ex_rd (ex_rd),
        .ex_wen(ex_wen),
        .ex_mrd(ex_mrd),
        .hit   (load_hit)
    );

    hz_stall_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hit(load_hit),
        .stall   (stall),
        .bubble  (bubble)
    );

    // R3
    mem_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && mem_rd != '0 && mem_rd == ex_rs1) |-> fwd_a == FWD_MEM);
    // R4
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs2 == '0) |-> fwd_b == FWD_NONE);
    // R7
    alu_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mrd |-> !stall);
    // R5
    bubble_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (bubble && ex_wen && ex_rd != '0));
endmodule

// File: tb/test_hz_fwd_unit.sv
module test_hz_fwd_unit;
    localparam int AW = 5;
    localparam time CLK_PERIOD = 10;

    typedef struct packed {
        logic [AW-1:0] id1, id2, ex1, ex2, exrd;
        logic exw, exm;
        logic [AW-1:0] memrd;
        logic memw;
        logic [AW-1:0] wbrd;
        logic wbw;
        logic [1:0] ea, eb;
        logic est;
    } vec_t;

    localparam int NV = 17;
    // id1 id2 ex1 ex2 exrd exw exm memrd memw wbrd wbw | a b stall
    localparam vec_t VECS [NV] = '{
        '{5'd6, 5'd7, 5'd1, 5'd2, 5'd5, 1'b1, 1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0}, // R2 no match
        '{5'd6, 5'd7, 5'd3, 5'd2, 5'd5, 1'b1, 1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 2'b10, 2'b00, 1'b0}, // R1 dist 1
        '{5'd6, 5'd7, 5'd1, 5'd4, 5'd5, 1'b1, 1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b01, 1'b0}, // R2 dist 2
        '{5'd6, 5'd7, 5'd8, 5'd8, 5'd5, 1'b1, 1'b0, 5'd8, 1'b1, 5'd8, 1'b1, 2'b10, 2'b10, 1'b0}, // R3 both
        '{5'd6, 5'd7, 5'd8, 5'd8, 5'd5, 1'b1, 1'b0, 5'd8, 1'b0, 5'd8, 1'b1, 2'b01, 2'b01, 1'b0}, // R4 mem wen low
        '{5'd6, 5'd7, 5'd0, 5'd0, 5'd5, 1'b1, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0}, // R4 reg zero
        '{5'd6, 5'd7, 5'd1, 5'd4, 5'd5, 1'b1, 1'b0, 5'd3, 1'b1, 5'd4, 1'b0, 2'b00, 2'b00, 1'b0}, // R4 wb wen low
        '{5'd4, 5'd7, 5'd1, 5'd2, 5'd5, 1'b1, 1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0}, // R7 dist 3
        '{5'd9, 5'd7, 5'd1, 5'd2, 5'd9, 1'b1, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b1}, // R5 load-use
        '{5'd9, 5'd7, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0}, // R6 bubble in EX
        '{5'd6, 5'd7, 5'd9, 5'd2, 5'd5, 1'b1, 1'b0, 5'd3, 1'b1, 5'd9, 1'b1, 2'b01, 2'b00, 1'b0}, // R2 load via WB
        '{5'd7, 5'd11, 5'd1, 5'd2, 5'd11, 1'b1, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b1}, // R5 rs2
        '{5'd7, 5'd11, 5'd1, 5'd2, 5'd11, 1'b1, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0}, // R6 held
        '{5'd7, 5'd11, 5'd1, 5'd2, 5'd11, 1'b1, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b1}, // R6 again
        '{5'd0, 5'd7, 5'd1, 5'd2, 5'd0, 1'b1, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0}, // R4 load to r0
        '{5'd12, 5'd7, 5'd1, 5'd2, 5'd12, 1'b0, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0}, // R4 load wen low
        '{5'd13, 5'd7, 5'd1, 5'd2, 5'd13, 1'b1, 1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0}  // R7 ALU in EX
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic [AW-1:0] mem_rd = '0, wb_rd = '0;
    logic ex_wen = 1'b0, ex_mrd = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic stall, bubble;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_fwd_unit #(.REG_AW(AW)) i_hz_fwd_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_mrd(ex_mrd),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        id_rs1 = v.id1; id_rs2 = v.id2; ex_rs1 = v.ex1; ex_rs2 = v.ex2;
        ex_rd = v.exrd; ex_wen = v.exw; ex_mrd = v.exm;
        mem_rd = v.memrd; mem_wen = v.memw; wb_rd = v.wbrd; wb_wen = v.wbw;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R8: load-use inputs under reset must not stall
        apply(VECS[8]);
        repeat (3) @(negedge clk);
        #1;
        check("R8 stall in reset", {1'b0, stall}, 2'b00);
        check("R8 bubble in reset", {1'b0, bubble}, 2'b00);
        apply(VECS[0]);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 idle after reset", {1'b0, stall}, 2'b00);
        // R8: first load-use after reset is in FLOW, stalls
        apply(VECS[8]);
        #1;
        check("R8 first stall", {1'b0, stall}, 2'b01);
        check("R5 bubble with stall", {1'b0, bubble}, 2'b01);
        @(negedge clk);
        apply(VECS[0]);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            #1;
            check($sformatf("R1/R2/R3/R4 vec%0d fwd_a", i), fwd_a, VECS[i].ea);
            check($sformatf("R1/R2/R3/R4 vec%0d fwd_b", i), fwd_b, VECS[i].eb);
            check($sformatf("R5/R6/R7 vec%0d stall", i), {1'b0, stall}, {1'b0, VECS[i].est});
            check($sformatf("R5 vec%0d bubble", i), {1'b0, bubble}, {1'b0, VECS[i].est});
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule